// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block decides which of a UART's four interrupt causes is reported to the host, publishes that cause as an identification code, and drives one interrupt request line. The four causes are receive line errors, received data waiting, an empty transmit holding register, and a change on a modem status line. Each cause has its own enable bit. When several causes are pending together, only the most urgent one is reported.

The transmit-empty cause does not follow the empty flag directly. A small two-state machine tracks it. The machine moves from `THR_IDLE` to `THR_ARMED` when the transmitter moves a byte from the holding register into its shift register (transition `ARM`). It returns to `THR_IDLE` when the host writes the holding register or reads the identification register (transition `ACK`). If both a move and an acknowledge happen in the same cycle, the arming is taken, so the machine ends in `THR_ARMED`. The identification code and the request line are registered and re-evaluated on every clock.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, the identification code is 0x01, the request line is low and the transmit latch is in `THR_IDLE`.
- R2: If enable bit 2 is set and any of the four line error inputs is high in a cycle, the code becomes 0x06 after the next clock edge.
- R3: If enable bit 0 and the data-ready input are both high in a cycle, and no higher cause is active, the code becomes 0x04 after the next clock edge.
- R4: The transmit cause is active only when enable bit 1, the holding-empty input and `THR_ARMED` are all true. A steady empty flag without a transfer never raises it, and the cause reports code 0x02.
- R5: A transfer pulse arms the latch at the clock edge it is sampled. A host write to the holding register returns the latch to `THR_IDLE` at its edge.
- R6: A host read of the identification register also returns the latch to `THR_IDLE`.
- R7: When a transfer and an identification read fall in the same cycle, the latch ends armed.
- R8: If enable bit 3 is set and any of the four modem delta inputs is high, and no higher cause is active, the code becomes 0x00.
- R9: The fixed order of causes is line error, then received data, then transmit empty, then modem change. The code always shows the highest active cause.
- R10: The request line is high exactly when the registered code differs from 0x01. With every cause disabled, the code stays 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en_i | input | 4 | Enables: [0] received data, [1] transmit empty, [2] line error, [3] modem change |
| line_err_i | input | 4 | Overrun, parity, framing and break flags |
| data_rdy_i | input | 1 | Received byte waiting |
| thr_empty_i | input | 1 | Holding register empty flag |
| thr_xfer_i | input | 1 | One-cycle pulse: byte moved from the holding register to the shift register |
| thr_wr_i | input | 1 | One-cycle pulse: host wrote the holding register |
| iid_rd_i | input | 1 | One-cycle pulse: host read the identification register |
| modem_delta_i | input | 4 | Modem status change flags |
| iid_o | output | 8 | Registered identification code |
| irq_o | output | 1 | Interrupt request line |

## Verification
The functions that can collide are the latch's arming by a transfer and its clearing by an identification read. The bench first arms the latch and confirms code 0x02. It then raises the transfer and read pulses in the same cycle and checks that 0x02 is still reported two edges later. Finally it issues a lone read and confirms the code falls back to 0x01. It also arms the latch and raises a higher cause in one cycle, and judges that the higher cause is reported while the transmit cause stays latched beneath it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NUM_SRC  = 4;
    localparam int CODE_W   = 8;

    // Source indices in priority order, highest first.
    localparam int SRC_LINE  = 0;
    localparam int SRC_RXD   = 1;
    localparam int SRC_THRE  = 2;
    localparam int SRC_MODEM = 3;

    // Enable bit positions inside the enable vector.
    localparam int EN_RXD   = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [CODE_W-1:0] {
        IID_NONE  = 8'h01,
        IID_LINE  = 8'h06,
        IID_RXD   = 8'h04,
        IID_THRE  = 8'h02,
        IID_MODEM = 8'h00
    } iid_code_e;

    typedef enum logic {
        THR_IDLE  = 1'b0,
        THR_ARMED = 1'b1
    } thr_state_e;

    function automatic iid_code_e code_of(input int src);
        unique case (src)
            SRC_LINE:  return IID_LINE;
            SRC_RXD:   return IID_RXD;
            SRC_THRE:  return IID_THRE;
            default:   return IID_MODEM;
        endcase
    endfunction
endpackage

// File: rtl/uart_thre_latch.sv
module uart_thre_latch
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_i,
    input  logic ack_i,
    output logic armed_o
);
    thr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= THR_IDLE;
        else        state_q <= state_d;
    end

    // ARM has precedence over ACK when both arrive together.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THR_IDLE:  if (xfer_i) state_d = THR_ARMED;
            THR_ARMED: if (ack_i && !xfer_i) state_d = THR_IDLE;
            default:   state_d = THR_IDLE;
        endcase
    end

    always_comb armed_o = (state_q == THR_ARMED);

    assert_arm_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> armed_o);
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !xfer_i) |=> !armed_o);
endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
    import uart_irq_pkg::*;
#(
    parameter int ERR_W   = 4,
    parameter int DELTA_W = 4
) (
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [ERR_W-1:0]   line_err_i,
    input  logic               data_rdy_i,
    input  logic               thr_empty_i,
    input  logic               thre_armed_i,
    input  logic [DELTA_W-1:0] modem_delta_i,
    output logic [NUM_SRC-1:0] pend_o
);
    always_comb begin
        pend_o            = '0;
        pend_o[SRC_LINE]  = en_i[EN_LINE]  && (|line_err_i);
        pend_o[SRC_RXD]   = en_i[EN_RXD]   && data_rdy_i;
        pend_o[SRC_THRE]  = en_i[EN_THRE]  && thr_empty_i && thre_armed_i;
        pend_o[SRC_MODEM] = en_i[EN_MODEM] && (|modem_delta_i);
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [NUM_SRC-1:0] grant_o,
    output iid_code_e          code_o
);
    // Lower index is more urgent; each stage is blocked by all above it.
    logic [NUM_SRC:0] blocked;
    assign blocked[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_stage
        assign grant_o[g]   = pend_i[g] && !blocked[g];
        assign blocked[g+1] = blocked[g] || pend_i[g];
    end

    always_comb begin
        code_o = IID_NONE;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (pend_i[s]) code_o = code_of(s);
        end
    end

    always_comb begin
        assert_single_grant_R9: assert ($onehot0(grant_o));
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int ERR_W   = 4,
    parameter int DELTA_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_en_i,
    input  logic [ERR_W-1:0]    line_err_i,
    input  logic                data_rdy_i,
    input  logic                thr_empty_i,
    input  logic                thr_xfer_i,
    input  logic                thr_wr_i,
    input  logic                iid_rd_i,
    input  logic [DELTA_W-1:0]  modem_delta_i,
    output logic [CODE_W-1:0]   iid_o,
    output logic                irq_o
);
    logic               armed;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;
    iid_code_e          code;
    iid_code_e          iid_q;
    logic               irq_q;
    logic               past_ok;

    uart_thre_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer_i  (thr_xfer_i),
        .ack_i   (thr_wr_i || iid_rd_i),
        .armed_o (armed)
    );

    uart_irq_sources #(.ERR_W(ERR_W), .DELTA_W(DELTA_W)) u_src (
        .en_i          (irq_en_i),
        .line_err_i    (line_err_i),
        .data_rdy_i    (data_rdy_i),
        .thr_empty_i   (thr_empty_i),
        .thre_armed_i  (armed),
        .modem_delta_i (modem_delta_i),
        .pend_o        (pend)
    );

    uart_irq_prio u_prio (
        .pend_i  (pend),
        .grant_o (grant),
        .code_o  (code)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iid_q   <= IID_NONE;
            irq_q   <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            iid_q   <= code;
            irq_q   <= |grant;
            past_ok <= 1'b1;
        end
    end

    assign iid_o = iid_q;
    assign irq_o = irq_q;

    assert_irq_matches_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (iid_o != IID_NONE));
    assert_line_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(irq_en_i[EN_LINE] && (|line_err_i)) |-> iid_o == IID_LINE);
    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(irq_en_i == '0) |-> !irq_o);
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] en, err, delta;
    logic       rdy, empty, xfer, wr, rd;
    logic [7:0] iid;
    logic       irq;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n), .irq_en_i(en), .line_err_i(err),
        .data_rdy_i(rdy), .thr_empty_i(empty), .thr_xfer_i(xfer),
        .thr_wr_i(wr), .iid_rd_i(rd), .modem_delta_i(delta),
        .iid_o(iid), .irq_o(irq)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] exp);
        logic exp_irq;
        exp_irq = (exp != 8'h01);
        n_chk++;
        if (iid !== exp || irq !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: iid=%02h irq=%0b expected iid=%02h irq=%0b",
                     req, iid, irq, exp, exp_irq);
        end
    endtask

    task automatic quiet();
        en = 0; err = 0; delta = 0; rdy = 0; empty = 0;
        xfer = 0; wr = 0; rd = 0;
    endtask

    task automatic do_reset();
        quiet();
        rst_n = 0; step(); step(); rst_n = 1;
        check("R1", 8'h01);
    endtask

    task automatic arm_latch();
        xfer = 1; step(); xfer = 0; step();
    endtask

    task automatic t_line();
        en = 4'b0100; err = 4'b1000; step(); check("R2", 8'h06);
        err = 4'b0010; step(); check("R2", 8'h06);
        en = 4'b0000; step(); check("R10", 8'h01);
        quiet(); step();
    endtask

    task automatic t_rxd();
        en = 4'b0001; rdy = 1; step(); check("R3", 8'h04);
        rdy = 0; step(); check("R3", 8'h01);
        quiet(); step();
    endtask

    task automatic t_thre_wr();
        en = 4'b0010; empty = 1; step(); step();
        check("R4", 8'h01);                 // steady empty, never armed
        xfer = 1; step(); xfer = 0;
        check("R5", 8'h01);                 // latch armed only at this edge
        step(); check("R4", 8'h02);
        empty = 0; step(); check("R4", 8'h01);
        empty = 1; step(); check("R5", 8'h02);
        wr = 1; step(); wr = 0; step(); check("R5", 8'h01);
        quiet(); step();
    endtask

    task automatic t_thre_rd();
        en = 4'b0010; empty = 1; arm_latch(); check("R6", 8'h02);
        rd = 1; step(); rd = 0; step(); check("R6", 8'h01);
        quiet(); step();
    endtask

    task automatic t_same_cycle();
        en = 4'b0010; empty = 1; arm_latch(); check("R7", 8'h02);
        rd = 1; xfer = 1; step(); rd = 0; xfer = 0; step();
        check("R7", 8'h02);
        rd = 1; step(); rd = 0; step(); check("R7", 8'h01);
        quiet(); step();
    endtask

    task automatic t_modem();
        en = 4'b1000; delta = 4'b0100; step(); check("R8", 8'h00);
        delta = 4'b0001; step(); check("R8", 8'h00);
        delta = 0; step(); check("R8", 8'h01);
        quiet(); step();
    endtask

    task automatic t_priority();
        en = 4'b1111; empty = 1; err = 4'b0001; rdy = 1; delta = 4'b1000;
        xfer = 1; step(); xfer = 0; check("R9", 8'h06);
        step(); check("R9", 8'h06);
        err = 0; step(); check("R9", 8'h04);
        rdy = 0; step(); check("R9", 8'h02);
        rd = 1; step(); rd = 0; step(); check("R9", 8'h00);
        delta = 0; step(); check("R9", 8'h01);
        quiet(); step();
    endtask

    task automatic t_all_off();
        en = 0; err = 4'hF; rdy = 1; empty = 1; delta = 4'hF; xfer = 1;
        step(); xfer = 0; step(); check("R10", 8'h01);
        quiet(); step();
    endtask

    task automatic t_reset_clears();
        en = 4'b0010; empty = 1; arm_latch(); check("R1", 8'h02);
        rst_n = 0; step(); rst_n = 1; check("R1", 8'h01);
        en = 4'b0010; empty = 1; step(); step(); check("R1", 8'h01);
        quiet(); step();
    endtask

    initial begin
        step();
        do_reset();
        t_line();
        t_rxd();
        t_thre_wr();
        t_thre_rd();
        t_same_cycle();
        t_modem();
        t_priority();
        t_all_off();
        t_reset_clears();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule